// File: doc/BRIEF.md
# Multi-Size Barrel Shifter with Condition Flags

This block is the shift execution unit of a 68000-style integer pipeline. It takes a 16-bit shift opcode, the destination operand and a count from a data register. It decodes the operand size, the shift kind and the count source from the opcode. It performs a logical left, logical right or arithmetic right shift on a byte, word or long operand, and registers both the merged destination value and the five condition flags.

A byte or word result replaces only the low part of the destination, and the rest of the register passes through unchanged. The memory form shifts a 16-bit word by exactly one position. The caller supplies that word in the low half of the operand input and takes it back from the low half of the result. Register counts run from 0 to 63, so the carry is defined for counts equal to the operand width and for counts beyond it.

Top module: `shift_unit`

## Requirements
- R1: Opcode bit 8 = 1 selects a logical left shift. When bit 8 = 0, bit 3 = 1 selects a logical right shift and bit 3 = 0 selects an arithmetic right shift.
- R2: Opcode bits 7:6 select the size: 00 = byte (8 bits), 01 = word (16 bits), 10 = long (32 bits). The value 11 is the memory form, which shifts a 16-bit word by exactly 1 and ignores bits 11:9 and bit 5.
- R3: Opcode bit 5 = 1 takes the count from the count input (6 bits, 0..63). Bit 5 = 0 takes the count from opcode bits 11:9, where 000 means 8.
- R4: With a count of 0, the operand is returned unchanged and C keeps its previous value.
- R5: For a left shift of width W by count n, C is operand bit W-n when 1 <= n < W. When n = W, the result is 0 and C is operand bit 0. When n > W, the result is 0 and C is 0.
- R6: For a logical right shift, C is operand bit n-1 when 1 <= n < W. When n = W, the result is 0 and C is operand bit W-1. When n > W, the result is 0 and C is 0.
- R7: For an arithmetic right shift, vacated bits take the sign bit. When n >= W, every result bit and C equal the sign bit.
- R8: The flag output is {X,N,Z,V,C} with C at bit 0, V at bit 1, Z at bit 2, N at bit 3 and X at bit 4. N is the result's top bit at the selected width, and Z is set when the result is zero at that width. V is always 0 and X always equals C.
- R9: Byte operations preserve result bits 31:8, and word and memory operations preserve bits 31:16, both taken from the destination input.
- R10: On a rising clock edge with enable high and opcode bits 15:12 = 1110, the result and flags update and are visible after that edge. Otherwise both outputs hold. Reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute strobe |
| opcode_i | input | 16 | Shift opcode |
| dst_i | input | 32 | Destination operand (memory word in bits 15:0) |
| cnt_i | input | 6 | Low bits of the count register |
| result_o | output | 32 | Registered merged result |
| flags_o | output | 5 | Registered flags {X,N,Z,V,C} |

## Verification
All state lives in the result and flag registers, so a wrong value appears at the ports on the clock edge after the strobe that produced it. A stale carry shows up only on a later zero-count shift, and only if that shift follows an operation that changed C. The stimulus therefore chains operations so that each zero count inherits a known, non-trivial carry. A wrong width selection corrupts either N and Z or the preserved upper bits, and both are compared against the destination input of the previous cycle.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int unsigned CNT_W = 6;
  localparam logic [3:0] SHIFT_GROUP = 4'hE;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_MEM  = 2'd3
  } shift_size_e;

  typedef struct packed {
    shift_kind_e       kind;
    shift_size_e       size;
    logic [CNT_W-1:0]  cnt;
  } shift_cmd_t;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_V = 1;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_X = 4;
  localparam int unsigned FLAG_W = 5;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [11:3]      fields_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  output shift_cmd_t       cmd_o
);
  logic [CNT_W-1:0] imm_cnt;

  always_comb begin
    imm_cnt = CNT_W'(fields_i[11:9]);
    if (fields_i[11:9] == 3'd0) imm_cnt = CNT_W'(8);

    cmd_o.size = shift_size_e'(fields_i[7:6]);
    if (fields_i[8])      cmd_o.kind = KIND_LSL;
    else if (fields_i[3]) cmd_o.kind = KIND_LSR;
    else                  cmd_o.kind = KIND_ASR;

    if (fields_i[7:6] == 2'b11) cmd_o.cnt = CNT_W'(1);
    else if (fields_i[5])       cmd_o.cnt = cnt_reg_i;
    else                        cmd_o.cnt = imm_cnt;
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  shift_kind_e      kind_i,
  input  logic             c_prev_i,
  output logic [W-1:0]     res_o,
  output logic             c_o
);
  // one guard bit beyond the operand catches the last bit shifted out
  logic        [W:0] lsl_ext;
  logic        [W:0] lsr_ext;
  logic signed [W:0] asr_ext;

  assign lsl_ext = {1'b0, val_i} << cnt_i;
  assign lsr_ext = {val_i, 1'b0} >> cnt_i;
  assign asr_ext = $signed({val_i, 1'b0}) >>> cnt_i;

  always_comb begin
    unique case (kind_i)
      KIND_LSL: begin res_o = lsl_ext[W-1:0]; c_o = lsl_ext[W]; end
      KIND_LSR: begin res_o = lsr_ext[W:1];   c_o = lsr_ext[0]; end
      default:  begin res_o = asr_ext[W:1];   c_o = asr_ext[0]; end
    endcase
    if (cnt_i == '0) begin
      res_o = val_i;
      c_o   = c_prev_i;
    end
  end
endmodule

// File: rtl/shift_flags.sv
module shift_flags
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  shift_size_e       size_i,
  input  logic              c_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned BW = DATA_W / 4;
  localparam int unsigned HW = DATA_W / 2;

  logic n, z;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin n = res_i[BW-1];     z = (res_i[BW-1:0] == '0); end
      SZ_LONG: begin n = res_i[DATA_W-1]; z = (res_i == '0);         end
      default: begin n = res_i[HW-1];     z = (res_i[HW-1:0] == '0); end
    endcase
    flags_o         = '0;
    flags_o[FLAG_C] = c_i;
    flags_o[FLAG_X] = c_i;
    flags_o[FLAG_N] = n;
    flags_o[FLAG_Z] = z;
    flags_o[FLAG_V] = 1'b0;
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned NSZ = 3;
  localparam int unsigned BW  = DATA_W / 4;
  localparam int unsigned HW  = DATA_W / 2;

  shift_cmd_t        cmd;
  logic [DATA_W-1:0] res_sz [NSZ];
  logic [NSZ-1:0]    c_sz;
  logic [DATA_W-1:0] merged;
  logic              c_new;
  logic [FLAG_W-1:0] flags_d;
  logic              fire;
  logic              unused_op;

  assign unused_op = ^{opcode_i[4], opcode_i[2:0]};
  assign fire = en_i && (opcode_i[15:12] == SHIFT_GROUP);

  shift_decode u_decode (
    .fields_i  (opcode_i[11:3]),
    .cnt_reg_i (cnt_i),
    .cmd_o     (cmd)
  );

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int unsigned W = BW << g;
    logic [W-1:0] res_w;
    shift_core #(.W(W)) u_core (
      .val_i    (dst_i[W-1:0]),
      .cnt_i    (cmd.cnt),
      .kind_i   (cmd.kind),
      .c_prev_i (flags_o[FLAG_C]),
      .res_o    (res_w),
      .c_o      (c_sz[g])
    );
    assign res_sz[g] = DATA_W'(res_w);
  end

  always_comb begin
    unique case (cmd.size)
      SZ_BYTE: begin merged = {dst_i[DATA_W-1:BW], res_sz[0][BW-1:0]}; c_new = c_sz[0]; end
      SZ_LONG: begin merged = res_sz[2];                                 c_new = c_sz[2]; end
      default: begin merged = {dst_i[DATA_W-1:HW], res_sz[1][HW-1:0]}; c_new = c_sz[1]; end
    endcase
  end

  shift_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i   (merged),
    .size_i  (cmd.size),
    .c_i     (c_new),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else if (fire) begin
      result_o <= merged;
      flags_o  <= flags_d;
    end
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [15:0]       opcode_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned BW = DATA_W / 4;
  localparam int unsigned HW = DATA_W / 2;

  logic fire;
  assign fire = en_i && (opcode_i[15:12] == SHIFT_GROUP);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> ($stable(result_o) && $stable(flags_o)));

  assert_v_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !flags_o[FLAG_V]);

  assert_x_is_c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (flags_o[FLAG_X] == flags_o[FLAG_C]));

  assert_byte_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode_i[7:6] == 2'b00) |=> (result_o[DATA_W-1:BW] == $past(dst_i[DATA_W-1:BW])));

  assert_word_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode_i[7] == 1'b0 && opcode_i[6] == 1'b1) |=> (result_o[DATA_W-1:HW] == $past(dst_i[DATA_W-1:HW])));

  assert_byte_z_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode_i[7:6] == 2'b00) |=> (flags_o[FLAG_Z] == (result_o[BW-1:0] == '0)));

  assert_zero_cnt_c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode_i[7:6] != 2'b11 && opcode_i[5] && cnt_i == '0) |=>
      (flags_o[FLAG_C] == $past(flags_o[FLAG_C]) && result_o == $past(dst_i)));

  assert_mem_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode_i[7:6] == 2'b11 && opcode_i[8]) |=> (result_o[HW-1:0] == {$past(dst_i[HW-2:0]), 1'b0}));
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .opcode_i (opcode_i),
  .dst_i    (dst_i),
  .cnt_i    (cnt_i),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/shift_unit_tb.sv
module shift_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [31:0] dst_i = '0;
  logic [5:0]  cnt_i = '0;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_res = '0;
  logic [4:0]  exp_flg = '0;

  always #4 clk_i = ~clk_i;

  shift_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .opcode_i(opcode_i),
    .dst_i(dst_i), .cnt_i(cnt_i), .result_o(result_o), .flags_o(flags_o)
  );

  // Step-by-step reference: one position per iteration.
  function automatic logic [36:0] model(logic [15:0] op, logic [31:0] d, logic [5:0] rc, logic cprev);
    int w, n;
    logic [31:0] mask, v;
    logic c, sgn;
    w = (op[7:6] == 2'b00) ? 8 : (op[7:6] == 2'b10) ? 32 : 16;
    if (op[7:6] == 2'b11) n = 1;
    else if (op[5]) n = int'(rc);
    else n = (op[11:9] == 3'd0) ? 8 : int'(op[11:9]);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    v = d & mask;
    sgn = v[w-1];
    c = cprev;
    for (int i = 0; i < n; i++) begin
      if (op[8]) begin
        c = v[w-1];
        v = (v << 1) & mask;
      end else begin
        c = v[0];
        v = v >> 1;
        if (!op[3] && sgn) v[w-1] = 1'b1;
      end
    end
    return {(d & ~mask) | v, c, v[w-1], (v == 32'h0), 1'b0, c};
  endfunction

  function automatic logic [15:0] mk(int kind, logic [1:0] sz, bit rg, logic [2:0] imm);
    logic [15:0] op;
    op = 16'hE000;
    op[11:9] = imm;
    op[8] = (kind == 0);
    op[7:6] = sz;
    op[5] = rg;
    op[3] = (kind == 1);
    return op;
  endfunction

  task automatic check(string req, logic [36:0] act, logic [36:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual res=%h flg=%b expected res=%h flg=%b",
               req, act[36:5], act[4:0], exp[36:5], exp[4:0]);
    end
  endtask

  task automatic run(string req, logic [15:0] op, logic [31:0] d, logic [5:0] rc, bit en);
    logic [36:0] m;
    @(negedge clk_i);
    opcode_i = op; dst_i = d; cnt_i = rc; en_i = en;
    if (en && op[15:12] == 4'hE) begin
      m = model(op, d, rc, exp_flg[0]);
      exp_res = m[36:5];
      exp_flg = m[4:0];
    end
    @(negedge clk_i);
    en_i = 1'b0;
    check(req, {result_o, flags_o}, {exp_res, exp_flg});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10: watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int widths[3];
    logic [1:0] sizes[3];
    int cnts[6];
    void'($urandom(32'd1234));
    widths = '{8, 16, 32};
    sizes = '{2'b00, 2'b01, 2'b10};
    repeat (3) @(negedge clk_i);
    check("R10 reset", {result_o, flags_o}, 37'h0);
    rst_ni = 1'b1;

    // R4: set C=1, then zero count keeps it and the operand
    run("R5 set carry", mk(0, 2'b00, 1, 3'd0), 32'h1234_5680, 6'd1, 1'b1);
    run("R4 zero count keeps C", mk(1, 2'b10, 1, 3'd0), 32'hCAFE_0001, 6'd0, 1'b1);
    run("R4 zero count byte", mk(2, 2'b00, 1, 3'd0), 32'h0000_00F0, 6'd0, 1'b1);
    // R3: immediate 000 means 8
    run("R3 imm 0 is 8", mk(1, 2'b01, 0, 3'd0), 32'h5555_AB00, 6'd1, 1'b1);
    run("R3 imm 3", mk(0, 2'b10, 0, 3'd3), 32'hF000_000F, 6'd0, 1'b1);
    // R2: memory form ignores count fields
    run("R2 memory lsl", mk(0, 2'b11, 1, 3'd5), 32'hABCD_8001, 6'd40, 1'b1);
    run("R2 memory asr", mk(2, 2'b11, 0, 3'd7), 32'h0000_8002, 6'd0, 1'b1);
    run("R2 memory lsr", mk(1, 2'b11, 1, 3'd2), 32'hFFFF_8003, 6'd9, 1'b1);
    // R10: non-group opcode and low enable are ignored
    run("R10 other group", 16'hD108, 32'h1111_1111, 6'd3, 1'b1);
    run("R10 no enable", mk(0, 2'b10, 1, 3'd0), 32'h2222_2222, 6'd1, 1'b0);

    // R5 R6 R7 R8 R9: directed count boundaries per size and kind
    for (int s = 0; s < 3; s++) begin
      cnts = '{1, widths[s] - 1, widths[s], widths[s] + 1, 63, 0};
      for (int k = 0; k < 3; k++) begin
        for (int c = 0; c < 6; c++) begin
          run(k == 0 ? "R5 left bound" : k == 1 ? "R6 lsr bound" : "R7 asr bound",
              mk(k, sizes[s], 1, 3'd0), 32'hA5C3_81B7, 6'(cnts[c]), 1'b1);
          run(k == 0 ? "R5 left bound" : k == 1 ? "R6 lsr bound" : "R7 asr bound",
              mk(k, sizes[s], 1, 3'd0), 32'h5A3C_7E41, 6'(cnts[c]), 1'b1);
        end
      end
    end
    run("R8 zero result Z", mk(0, 2'b00, 1, 3'd0), 32'hFFFF_FF01, 6'd8, 1'b1);
    run("R9 word upper kept", mk(1, 2'b01, 0, 3'd1), 32'h89AB_FFFF, 6'd0, 1'b1);

    // R1 R8 R9: random opcodes, operands and counts
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] op;
      op = 16'($urandom);
      if (($urandom % 8) != 0) op[15:12] = 4'hE;
      run("R1 random", op, $urandom, 6'($urandom), ($urandom % 6) != 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule